// File: doc/BRIEF.md
# Floating-Point Maximum / Minimum Selector

This block is a purely combinational selector that returns the larger or the smaller of two IEEE-754 values, in single or double precision. Two operands arrive as raw bit patterns next to a precision select, a two-bit operation code and a default-NaN mode bit. The result bits appear in the same cycle. It serves as the min/max leg of a floating-point execution unit, where the surrounding pipeline registers its inputs and output.

Four operations are provided. Plain maximum and minimum treat any NaN operand as a NaN result. The number-preferring variants (maxNum, minNum) return the numeric operand when the other one is a lone quiet NaN. Signed zeros are strictly ordered, so that -0 sorts below +0. A NaN result either keeps the payload of the chosen operand with its quiet bit set, or is replaced by the canonical default NaN when that mode is on. Subnormal encodings are compared by their bit value, exactly like normal ones. No exception flags are produced.

Top module: `fp_minmax`

## Requirements
- R1: With opSel 2'b00 (max) and two non-NaN operands, the result is the numerically larger operand; when the two are equal the result is operand A.
- R2: With opSel 2'b01 (min) and two non-NaN operands, the result is the numerically smaller operand, and infinities order beyond every finite value.
- R3: Zeros of opposite sign are ordered -0 < +0, so max of the pair is +0 and min is -0, whichever operand holds which.
- R4: For max and min, a NaN operand gives a NaN result chosen by priority: signalling NaN of A, signalling NaN of B, quiet NaN of A, quiet NaN of B. The chosen NaN keeps sign and payload and has its quiet bit set (bit 22 in single, bit 51 in double).
- R5: With opSel 2'b10 (maxNum) or 2'b11 (minNum), a quiet NaN facing a non-NaN operand is replaced by the losing infinity, so the result is the other operand.
- R6: In maxNum/minNum, a signalling NaN on either side, or quiet NaNs on both sides, are resolved as in R4.
- R7: With defaultNan high, every NaN result is 0x7FC00000 in single and 0x7FF8000000000000 in double; non-NaN results do not change.
- R8: With isDouble low, only operand bits [31:0] are used, bits [63:32] of both operands have no effect, and result bits [63:32] are zero.
- R9: Non-NaN ordering is sign-magnitude: a positive value beats a negative one, a larger magnitude is smaller among negatives, and subnormals order by encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First operand bits (single uses [31:0]) |
| opB | input | 64 | Second operand bits (single uses [31:0]) |
| isDouble | input | 1 | 1 = double precision, 0 = single precision |
| opSel | input | 2 | 00 max, 01 min, 10 maxNum, 11 minNum |
| defaultNan | input | 1 | 1 = NaN results become the default NaN |
| result | output | 64 | Selected value bits |

## Verification
Every result is combinational, so it is due in the same cycle its inputs are applied, with zero register stages in between. The bench changes all inputs just after a rising clock edge and reads the result at the following falling edge. This leaves half a period for the comparison network to settle and keeps each check clear of any edge ordering. No stimulus leaves a result pending for a later cycle, so each check covers only the vector applied just before it.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int WORD_W  = 64;
  localparam int SGL_W   = 32;
  localparam int SGL_EXP = 8;
  localparam int SGL_MAN = 23;
  localparam int DBL_EXP = 11;
  localparam int DBL_MAN = 52;
  localparam int MAG_W   = WORD_W - 1;

  localparam logic [WORD_W-1:0] SGL_DNAN = WORD_W'(64'h7FC0_0000);
  localparam logic [WORD_W-1:0] DBL_DNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [WORD_W-1:0] SGL_QBIT = WORD_W'(1) << (SGL_MAN - 1);
  localparam logic [WORD_W-1:0] DBL_QBIT = WORD_W'(1) << (DBL_MAN - 1);

  typedef enum logic [1:0] {
    OP_MAX    = 2'b00,
    OP_MIN    = 2'b01,
    OP_MAXNUM = 2'b10,
    OP_MINNUM = 2'b11
  } opSel_e;

  typedef struct packed {
    logic             sign;
    logic             isNan;
    logic             isSnan;
    logic             isQnan;
    logic [MAG_W-1:0] mag;
  } opClass_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic pickB;       // select operand B instead of A
    logic quietPick;   // force the quiet bit on the selected operand
    logic useDefault;  // replace the result by the default NaN
  } strobe_t;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
(
  input  logic [WORD_W-1:0] operand,
  input  logic              isDouble,
  output opClass_t          cls
);
  logic expOnes;
  logic manNonZero;
  logic quietBit;

  always_comb begin
    if (isDouble) begin
      expOnes    = &operand[WORD_W-2 -: DBL_EXP];
      manNonZero = |operand[DBL_MAN-1:0];
      quietBit   = operand[DBL_MAN-1];
      cls.sign   = operand[WORD_W-1];
      cls.mag    = operand[MAG_W-1:0];
    end else begin
      expOnes    = &operand[SGL_W-2 -: SGL_EXP];
      manNonZero = |operand[SGL_MAN-1:0];
      quietBit   = operand[SGL_MAN-1];
      cls.sign   = operand[SGL_W-1];
      cls.mag    = MAG_W'(operand[SGL_W-2:0]);
    end
    cls.isNan  = expOnes & manNonZero;
    cls.isQnan = cls.isNan & quietBit;
    cls.isSnan = cls.isNan & ~quietBit;
  end
endmodule

// File: rtl/fpmm_ctrl.sv
module fpmm_ctrl
  import fpmm_pkg::*;
(
  input  opClass_t   clsA,
  input  opClass_t   clsB,
  input  logic [1:0] opSel,
  input  logic       defaultNan,
  output strobe_t    strobe
);
  opSel_e opCode;
  logic   nmMode;
  logic   wantMin;
  logic   loneQnanA;
  logic   loneQnanB;
  logic   anyNan;
  logic   aGreater;
  logic   aEqual;
  logic   propPickB;

  assign opCode  = opSel_e'(opSel);
  assign nmMode  = (opCode == OP_MAXNUM) || (opCode == OP_MINNUM);
  assign wantMin = (opCode == OP_MIN) || (opCode == OP_MINNUM);

  assign loneQnanA = nmMode & clsA.isQnan & ~clsB.isNan;
  assign loneQnanB = nmMode & clsB.isQnan & ~clsA.isNan;
  assign anyNan    = clsA.isNan | clsB.isNan;

  // Propagation priority: sNaN A, sNaN B, qNaN A, qNaN B.
  assign propPickB = ~(clsA.isSnan | (~clsB.isSnan & clsA.isNan));

  // Sign-magnitude ordering, -0 below +0.
  always_comb begin
    aEqual = (clsA.sign == clsB.sign) && (clsA.mag == clsB.mag);
    if (clsA.sign != clsB.sign) begin
      aGreater = ~clsA.sign;
    end else if (!clsA.sign) begin
      aGreater = clsA.mag > clsB.mag;
    end else begin
      aGreater = clsA.mag < clsB.mag;
    end
  end

  always_comb begin
    strobe = '0;
    if (loneQnanA) begin
      strobe.pickB = 1'b1;
    end else if (loneQnanB) begin
      strobe.pickB = 1'b0;
    end else if (anyNan) begin
      strobe.pickB      = propPickB;
      strobe.quietPick  = 1'b1;
      strobe.useDefault = defaultNan;
    end else if (wantMin) begin
      strobe.pickB = aGreater;
    end else begin
      strobe.pickB = ~(aGreater | aEqual);
    end
  end
endmodule

// File: rtl/fpmm_datapath.sv
module fpmm_datapath
  import fpmm_pkg::*;
(
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              isDouble,
  input  strobe_t           strobe,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] picked;
  logic [WORD_W-1:0] laneMask;

  assign laneMask = isDouble ? '1 : WORD_W'({SGL_W{1'b1}});

  always_comb begin
    picked = (strobe.pickB ? opB : opA) & laneMask;
    if (strobe.useDefault) begin
      result = isDouble ? DBL_DNAN : SGL_DNAN;
    end else if (strobe.quietPick) begin
      result = picked | (isDouble ? DBL_QBIT : SGL_QBIT);
    end else begin
      result = picked;
    end
  end
endmodule

// File: rtl/fp_minmax.sv
module fp_minmax
  import fpmm_pkg::*;
(
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic        isDouble,
  input  logic [1:0]  opSel,
  input  logic        defaultNan,
  output logic [63:0] result
);
  localparam int N_OPS = 2;

  logic [WORD_W-1:0] operandArr [N_OPS];
  opClass_t          clsArr     [N_OPS];
  strobe_t           strobe;

  assign operandArr[0] = opA;
  assign operandArr[1] = opB;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fpmm_classify u_cls (
      .operand  (operandArr[gi]),
      .isDouble (isDouble),
      .cls      (clsArr[gi])
    );
  end

  fpmm_ctrl u_ctrl (
    .clsA       (clsArr[0]),
    .clsB       (clsArr[1]),
    .opSel      (opSel),
    .defaultNan (defaultNan),
    .strobe     (strobe)
  );

  fpmm_datapath u_dp (
    .opA      (opA),
    .opB      (opB),
    .isDouble (isDouble),
    .strobe   (strobe),
    .result   (result)
  );
endmodule

// File: rtl/fp_minmax_chk.sv
module fp_minmax_chk (
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic        isDouble,
  input logic [1:0]  opSel,
  input logic        defaultNan,
  input logic [63:0] result
);
  logic resNan;
  logic resQuiet;
  logic [63:0] mA, mB;
  logic zA, zB;

  always_comb begin
    mA = isDouble ? opA : {32'h0, opA[31:0]};
    mB = isDouble ? opB : {32'h0, opB[31:0]};
    if (isDouble) begin
      resNan   = (&result[62:52]) && (|result[51:0]);
      resQuiet = result[51];
      zA = (opA[62:0] == '0);
      zB = (opB[62:0] == '0);
    end else begin
      resNan   = (&result[30:23]) && (|result[22:0]);
      resQuiet = result[22];
      zA = (opA[30:0] == '0);
      zB = (opB[30:0] == '0);
    end

    a_r8_upper_zero: assert (isDouble || result[63:32] == 32'h0)
      else $error("upper result bits set in single mode");
    a_r4_quiet_nan: assert (!resNan || resQuiet)
      else $error("NaN result not quiet");
    a_r7_default_nan: assert (!(defaultNan && resNan) ||
                              result == (isDouble ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000))
      else $error("default NaN mode violated");
    a_r1_operand_pick: assert (resNan || result == mA || result == mB)
      else $error("non-NaN result is neither operand");
    a_r3_signed_zero: assert (!(zA && zB && (mA != mB)) ||
                              (opSel[0] ? (result != (isDouble ? 64'h0 : 64'h0))
                                        : (result == 64'h0)))
      else $error("signed zero ordering violated");
  end
endmodule

bind fp_minmax fp_minmax_chk u_chk (.*);

// File: tb/fp_minmax_test.sv
module fp_minmax_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] opA, opB;
  logic        isDouble;
  logic [1:0]  opSel;
  logic        defaultNan;
  logic [63:0] result;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  fp_minmax uut (
    .opA(opA), .opB(opB), .isDouble(isDouble),
    .opSel(opSel), .defaultNan(defaultNan), .result(result)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        dbl;
    logic [1:0]  op;
    logic        dn;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 35;
  // Requirement tags per entry: R1 R2 R3 R4 R5 R6 R7 R8 R9 (field req).
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0, 2'b00, 1'b0, 64'h3F800000, 64'h40000000, 64'h40000000}, // R1
    '{4'd1, 1'b0, 2'b00, 1'b0, 64'h40000000, 64'h3F800000, 64'h40000000}, // R1
    '{4'd2, 1'b0, 2'b01, 1'b0, 64'h3F800000, 64'h40000000, 64'h3F800000}, // R2
    '{4'd9, 1'b0, 2'b00, 1'b0, 64'hBF800000, 64'hC0000000, 64'hBF800000}, // R9
    '{4'd9, 1'b0, 2'b01, 1'b0, 64'hBF800000, 64'hC0000000, 64'hC0000000}, // R9
    '{4'd9, 1'b0, 2'b00, 1'b0, 64'hBF800000, 64'h3F800000, 64'h3F800000}, // R9
    '{4'd3, 1'b0, 2'b00, 1'b0, 64'h00000000, 64'h80000000, 64'h00000000}, // R3
    '{4'd3, 1'b0, 2'b00, 1'b0, 64'h80000000, 64'h00000000, 64'h00000000}, // R3
    '{4'd3, 1'b0, 2'b01, 1'b0, 64'h00000000, 64'h80000000, 64'h80000000}, // R3
    '{4'd3, 1'b0, 2'b01, 1'b0, 64'h80000000, 64'h00000000, 64'h80000000}, // R3
    '{4'd4, 1'b0, 2'b00, 1'b0, 64'h7FC00001, 64'h3F800000, 64'h7FC00001}, // R4
    '{4'd4, 1'b0, 2'b00, 1'b0, 64'h3F800000, 64'h7F800001, 64'h7FC00001}, // R4
    '{4'd4, 1'b0, 2'b01, 1'b0, 64'h7FC00123, 64'hFF800005, 64'hFFC00005}, // R4
    '{4'd4, 1'b0, 2'b00, 1'b0, 64'h7F800001, 64'hFF800005, 64'h7FC00001}, // R4
    '{4'd4, 1'b0, 2'b00, 1'b0, 64'h7FC00123, 64'h7FC00001, 64'h7FC00123}, // R4
    '{4'd5, 1'b0, 2'b10, 1'b0, 64'h7FC00001, 64'h3F800000, 64'h3F800000}, // R5
    '{4'd5, 1'b0, 2'b10, 1'b0, 64'hFF800000, 64'h7FC00001, 64'hFF800000}, // R5
    '{4'd5, 1'b0, 2'b11, 1'b0, 64'h3F800000, 64'h7FC00001, 64'h3F800000}, // R5
    '{4'd5, 1'b0, 2'b11, 1'b0, 64'h7FC00001, 64'h7F800000, 64'h7F800000}, // R5
    '{4'd6, 1'b0, 2'b10, 1'b0, 64'h7F800001, 64'h3F800000, 64'h7FC00001}, // R6
    '{4'd6, 1'b0, 2'b11, 1'b0, 64'h7FC00123, 64'h7FC00001, 64'h7FC00123}, // R6
    '{4'd6, 1'b0, 2'b11, 1'b0, 64'h3F800000, 64'hFF800005, 64'hFFC00005}, // R6
    '{4'd7, 1'b0, 2'b00, 1'b1, 64'h7FC00123, 64'h3F800000, 64'h7FC00000}, // R7
    '{4'd7, 1'b1, 2'b00, 1'b1, 64'h7FF0000000000009, 64'h3FF0000000000000, 64'h7FF8000000000000}, // R7
    '{4'd7, 1'b0, 2'b10, 1'b1, 64'h7FC00001, 64'h40000000, 64'h40000000}, // R7
    '{4'd1, 1'b1, 2'b00, 1'b0, 64'h3FF0000000000000, 64'h4000000000000000, 64'h4000000000000000}, // R1
    '{4'd9, 1'b1, 2'b01, 1'b0, 64'hBFF0000000000000, 64'hC000000000000000, 64'hC000000000000000}, // R9
    '{4'd4, 1'b1, 2'b00, 1'b0, 64'h7FF8000000000001, 64'h7FF0000000000009, 64'h7FF8000000000009}, // R4
    '{4'd9, 1'b1, 2'b00, 1'b0, 64'h0000000000000001, 64'h0000000000000002, 64'h0000000000000002}, // R9
    '{4'd2, 1'b1, 2'b01, 1'b0, 64'h7FF0000000000000, 64'h4000000000000000, 64'h4000000000000000}, // R2
    '{4'd8, 1'b0, 2'b00, 1'b0, 64'hDEADBEEF3F800000, 64'h1234567840000000, 64'h0000000040000000}, // R8
    '{4'd8, 1'b0, 2'b00, 1'b0, 64'hAAAA00003F800000, 64'h000055553F800000, 64'h000000003F800000}, // R8
    '{4'd3, 1'b1, 2'b00, 1'b0, 64'h0000000000000000, 64'h8000000000000000, 64'h0000000000000000}, // R3
    '{4'd5, 1'b1, 2'b11, 1'b0, 64'h7FF8000000000001, 64'hC000000000000000, 64'hC000000000000000}, // R5
    '{4'd8, 1'b0, 2'b00, 1'b0, 64'hFFFFFFFF7F800001, 64'h000000003F800000, 64'h000000007FC00001}  // R8
  };

  task automatic checkOut(input int req, input logic [63:0] expv, input string tag);
    nChecks++;
    if (result !== expv) begin
      nFails++;
      $display("FAIL R%0d %s: got %h expected %h", req, tag, result, expv);
    end
  endtask

  task automatic apply(input logic dbl, input logic [1:0] op, input logic dn,
                       input logic [63:0] a, input logic [63:0] b);
    @(posedge clk);
    #0.5;
    isDouble = dbl; opSel = op; defaultNan = dn; opA = a; opB = b;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #200000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    opA = '0; opB = '0; isDouble = 1'b0; opSel = 2'b00; defaultNan = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset-time quiescent inputs: max(+0,+0) gives +0 (R1).
    checkOut(1, 64'h0, "reset state");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].dbl, VECS[i].op, VECS[i].dn, VECS[i].a, VECS[i].b);
      checkOut(int'(VECS[i].req), VECS[i].exp, $sformatf("vector %0d", i));
    end

    // R1: equal operands return A, seen through upper bits in double mode
    apply(1'b1, 2'b00, 1'b0, 64'h4000000000000000, 64'h4000000000000000);
    checkOut(1, 64'h4000000000000000, "equal double");
    // R7: default mode leaves a number-preferred result untouched (double)
    apply(1'b1, 2'b11, 1'b1, 64'h3FF0000000000000, 64'h7FF8000000000005);
    checkOut(7, 64'h3FF0000000000000, "dn on non-NaN result");
    // R6: two quiet NaNs in maxNum, double, priority to A
    apply(1'b1, 2'b10, 1'b0, 64'hFFF8000000000003, 64'h7FF8000000000001);
    checkOut(6, 64'hFFF8000000000003, "maxNum two qNaN");
    // R2: min against negative infinity
    apply(1'b0, 2'b01, 1'b0, 64'hFF800000, 64'hC0000000);
    checkOut(2, 64'hFF800000, "min -inf");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule